// File: doc/BRIEF.md
# FM Operator Log-Sine Waveform Unit

This unit turns a stream of operator slot requests into signed waveform samples for a time-multiplexed FM voice engine. Each slot has its own phase accumulator. Every request names a slot and supplies four values: a phase step, a flag that suppresses that step, a modulation offset and an envelope attenuation. The unit reads the slot's current phase and adds the modulation to form a waveform index. It then produces the sample. The updated phase is written back for the slot's next turn.

The sine is never multiplied. The index is folded onto a quarter wave, and a log-sine table gives the attenuation of that point. The envelope is added in the log domain, and the sum is turned back into a linear value with a 256-entry power-of-two table and a right shift. The sign is applied last. Both tables are computed while the design elaborates. Step calculation, envelope shaping and operator routing belong to neighbouring blocks.

Top module: `wfu_operator`

## Requirements
- R1: A synchronous reset clears every phase accumulator to zero. It also drives out_valid low and out_sample to zero.
- R2: A request without the suppress flag adds phase_inc to the addressed slot's 20-bit accumulator, modulo 2^20. The new value is seen by that slot's next request.
- R3: When phase_rst is high, the request adds nothing, and the slot's accumulator keeps its value.
- R4: The 10-bit waveform index is (mod_in + accumulator[19:10]) mod 1024. It uses the accumulator value from before the request's own update.
- R5: Index bit 8 selects the falling half of the quarter wave. When it is set, the 8-bit table address is the bitwise inverse of index[7:0]; otherwise it is index[7:0].
- R6: The attenuation is logsine[address] + 4*env_lvl, limited to 0x1FFF. Log-sine entry i is round(-log2(sin((i+0.5)*pi/512))*256). The largest env_lvl always yields a zero sample.
- R7: The magnitude is ((E | 0x400) * 4) >> (atten >> 8). E is round((2^(k/256)-1)*1024) with k = 255 - (atten & 0xFF). The magnitude never exceeds 8168.
- R8: When index bit 9 is set, the sample is the negated magnitude; otherwise it is the magnitude.
- R9: A request accepted on one rising edge appears after exactly one register stage: out_valid high, out_slot equal to the request's slot. With no request, out_valid is low and out_sample is zero.
- R10: Slots are independent: a request to one slot leaves every other slot's accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A slot request is present |
| in_slot | input | SLOT_W | Slot addressed by the request |
| phase_inc | input | PHASE_W | Phase step for the slot |
| phase_rst | input | 1 | Suppress the phase step for this request |
| mod_in | input | 10 | Modulation added to the index |
| env_lvl | input | ENV_W | Envelope attenuation, log domain |
| out_valid | output | 1 | Sample present |
| out_slot | output | SLOT_W | Slot of the sample |
| out_sample | output | OUT_W | Signed sample |

## Verification
The bench builds the unit with four slots and keeps the 20-bit phase and 10-bit envelope defaults. With four slots, a few requests reach the accumulator wraparound and let the bench interleave every slot. Driving slot 0 with a zero step pins its phase, so mod_in alone selects any exact index. That exposes the fold boundary at 0xFF/0x100, both sign halves, and the peak and full-attenuation ends of the tables. The 0x1FFF clamp lies beyond what a 10-bit envelope can reach. Only the zero-sample property at the largest level is therefore in reach, and that is what the bench checks.

// File: rtl/wfu_pkg.sv
package wfu_pkg;
    localparam int IDX_W  = 10;
    localparam int QTR_W  = IDX_W - 2;
    localparam int TBL_N  = 2 ** QTR_W;
    localparam int LS_W   = 12;
    localparam int EX_W   = 10;
    localparam int ATT_W  = 13;
    localparam int MAG_W  = EX_W + 3;
    localparam real PI_R  = 3.14159265358979323846;

    // attenuation (1/256 of an octave) of one quarter-wave point
    function automatic int logsin_entry(int i);
        real s;
        s = $sin((real'(i) + 0.5) * PI_R / (2.0 * real'(TBL_N)));
        return $rtoi(-($ln(s) / $ln(2.0)) * 256.0 + 0.5);
    endfunction

    // fractional part of 2^(k/256), scaled to 10 bits
    function automatic int exp_entry(int k);
        return $rtoi(($pow(2.0, real'(k) / real'(TBL_N)) - 1.0) * 1024.0 + 0.5);
    endfunction
endpackage

// File: rtl/wfu_tables.sv
module wfu_tables
    import wfu_pkg::*;
(
    input  logic [QTR_W-1:0] ls_addr,
    input  logic [QTR_W-1:0] ex_addr,
    output logic [LS_W-1:0]  ls_val,
    output logic [EX_W-1:0]  ex_val
);
    logic [LS_W-1:0] ls_tab [TBL_N];
    logic [EX_W-1:0] ex_tab [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_rom
        localparam int LSV = logsin_entry(g);
        localparam int EXV = exp_entry(g);
        assign ls_tab[g] = LS_W'(LSV);
        assign ex_tab[g] = EX_W'(EXV);
    end

    assign ls_val = ls_tab[ls_addr];
    assign ex_val = ex_tab[ex_addr];
endmodule

// File: rtl/wfu_phase_bank.sv
module wfu_phase_bank
    import wfu_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int PHASE_W   = 20,
    parameter int SLOT_W    = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [PHASE_W-1:0] step,
    input  logic               hold,
    output logic [IDX_W-1:0]   idx_base
);
    logic [PHASE_W-1:0] acc_q [NUM_SLOTS];
    logic [PHASE_W-1:0] acc_d [NUM_SLOTS];
    logic [PHASE_W-1:0] rd_val;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb begin
            acc_d[g] = acc_q[g];
            if (wr_en && slot == SLOT_W'(g)) begin
                acc_d[g] = acc_q[g] + (hold ? '0 : step);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) acc_q[g] <= '0;
            else     acc_q[g] <= acc_d[g];
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot == SLOT_W'(i)) rd_val = acc_q[i];
        end
    end

    assign idx_base = rd_val[PHASE_W-1 -: IDX_W];
endmodule

// File: rtl/wfu_shaper.sv
module wfu_shaper
    import wfu_pkg::*;
#(
    parameter int ENV_W = 10,
    parameter int OUT_W = 14
) (
    input  logic [IDX_W-1:0]        wave_idx,
    input  logic [ENV_W-1:0]        env_lvl,
    output logic signed [OUT_W-1:0] sample
);
    localparam int W0    = (ENV_W + 2 > LS_W) ? ENV_W + 2 : LS_W;
    localparam int W1    = (W0 > ATT_W) ? W0 : ATT_W;
    localparam int SUM_W = W1 + 1;
    localparam logic [SUM_W-1:0] ATT_MAX = SUM_W'((1 << ATT_W) - 1);

    logic [QTR_W-1:0] qaddr;
    logic [LS_W-1:0]  ls_val;
    logic [EX_W-1:0]  ex_val;
    logic [SUM_W-1:0] sum;
    logic [ATT_W-1:0] atten;
    logic [MAG_W-1:0] mag;

    wfu_tables u_tab (
        .ls_addr (qaddr),
        .ex_addr (~atten[QTR_W-1:0]),
        .ls_val  (ls_val),
        .ex_val  (ex_val)
    );

    always_comb begin
        qaddr = wave_idx[QTR_W] ? ~wave_idx[QTR_W-1:0] : wave_idx[QTR_W-1:0];
        sum   = SUM_W'(ls_val) + (SUM_W'(env_lvl) << 2);
        atten = (sum > ATT_MAX) ? ATT_MAX[ATT_W-1:0] : sum[ATT_W-1:0];
        mag   = {1'b1, ex_val, 2'b00} >> atten[ATT_W-1:QTR_W];
        sample = wave_idx[IDX_W-1] ? -OUT_W'(mag) : OUT_W'(mag);
    end
endmodule

// File: rtl/wfu_operator.sv
module wfu_operator
    import wfu_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int PHASE_W   = 20,
    parameter int ENV_W     = 10,
    parameter int OUT_W     = 14,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [SLOT_W-1:0]       in_slot,
    input  logic [PHASE_W-1:0]      phase_inc,
    input  logic                    phase_rst,
    input  logic [IDX_W-1:0]        mod_in,
    input  logic [ENV_W-1:0]        env_lvl,
    output logic                    out_valid,
    output logic [SLOT_W-1:0]       out_slot,
    output logic signed [OUT_W-1:0] out_sample
);
    typedef struct packed {
        logic                    vld;
        logic [SLOT_W-1:0]       slot;
        logic signed [OUT_W-1:0] smp;
    } stage_t;

    stage_t pipe_d, pipe_q;

    logic [IDX_W-1:0]        idx_base;
    logic [IDX_W-1:0]        wave_idx;
    logic signed [OUT_W-1:0] shaped;

    wfu_phase_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .PHASE_W   (PHASE_W),
        .SLOT_W    (SLOT_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (in_valid),
        .slot     (in_slot),
        .step     (phase_inc),
        .hold     (phase_rst),
        .idx_base (idx_base)
    );

    assign wave_idx = mod_in + idx_base;

    wfu_shaper #(
        .ENV_W (ENV_W),
        .OUT_W (OUT_W)
    ) u_shape (
        .wave_idx (wave_idx),
        .env_lvl  (env_lvl),
        .sample   (shaped)
    );

    always_comb begin
        pipe_d      = '0;
        pipe_d.vld  = in_valid;
        if (in_valid) begin
            pipe_d.slot = in_slot;
            pipe_d.smp  = shaped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign out_valid  = pipe_q.vld;
    assign out_slot   = pipe_q.slot;
    assign out_sample = pipe_q.smp;
endmodule

// File: rtl/wfu_checker.sv
module wfu_checker #(
    parameter int SLOT_W = 5,
    parameter int ENV_W  = 10,
    parameter int OUT_W  = 14,
    parameter int IDX_W  = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [SLOT_W-1:0]       in_slot,
    input logic                    phase_rst,
    input logic [ENV_W-1:0]        env_lvl,
    input logic [IDX_W-1:0]        idx_base,
    input logic                    out_valid,
    input logic [SLOT_W-1:0]       out_slot,
    input logic signed [OUT_W-1:0] out_sample
);
    a_r9_valid_pipe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_sample == '0));

    a_r9_slot_echo: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_slot == $past(in_slot));

    a_r3_phase_held: assert property (@(posedge clk) disable iff (rst)
        (in_valid && phase_rst) ##1 (in_valid && in_slot == $past(in_slot))
        |-> idx_base == $past(idx_base));

    a_r6_full_env_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && env_lvl == '1) |=> out_sample == '0);

    a_r7_peak_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sample <= 8168 && out_sample >= -8168));
endmodule

bind wfu_operator wfu_checker #(
    .SLOT_W (SLOT_W),
    .ENV_W  (ENV_W),
    .OUT_W  (OUT_W),
    .IDX_W  (wfu_pkg::IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_slot    (in_slot),
    .phase_rst  (phase_rst),
    .env_lvl    (env_lvl),
    .idx_base   (idx_base),
    .out_valid  (out_valid),
    .out_slot   (out_slot),
    .out_sample (out_sample)
);

// File: tb/sim_wfu_operator.sv
`timescale 1ns/1ps
module sim_wfu_operator;
    localparam int NS = 4;
    localparam int SW = 2;

    logic              clk = 0;
    logic              rst = 1;
    logic              in_valid = 0;
    logic [SW-1:0]     in_slot = '0;
    logic [19:0]       phase_inc = '0;
    logic              phase_rst = 0;
    logic [9:0]        mod_in = '0;
    logic [9:0]        env_lvl = '0;
    logic              out_valid;
    logic [SW-1:0]     out_slot;
    logic signed [13:0] out_sample;

    int n_chk = 0;
    int n_bad = 0;
    int last_smp;
    logic [19:0] ph [NS];

    always #4 clk = ~clk;

    wfu_operator #(.NUM_SLOTS(NS), .PHASE_W(20), .ENV_W(10), .OUT_W(14)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_slot(in_slot),
        .phase_inc(phase_inc), .phase_rst(phase_rst), .mod_in(mod_in),
        .env_lvl(env_lvl), .out_valid(out_valid), .out_slot(out_slot),
        .out_sample(out_sample)
    );

    function automatic int ref_ls(int q);
        real s;
        s = $sin((real'(q) + 0.5) * 3.14159265358979323846 / 512.0);
        return $rtoi(-($ln(s) / $ln(2.0)) * 256.0 + 0.5);
    endfunction

    function automatic int ref_ex(int k);
        return $rtoi(($pow(2.0, real'(k) / 256.0) - 1.0) * 1024.0 + 0.5);
    endfunction

    function automatic int ref_sample(int idx, int env);
        int q, att, mag;
        q = ((idx & 256) != 0) ? (~idx & 255) : (idx & 255);
        att = ref_ls(q) + env * 4;
        if (att > 8191) att = 8191;
        mag = ((ref_ex(255 - (att & 255)) | 1024) * 4) >> (att >> 8);
        return ((idx & 512) != 0) ? -mag : mag;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one request; checks valid, slot and sample one register stage later
    task automatic op(int slot, int inc, bit prst, int md, int env, string req);
        int idx, expv;
        @(negedge clk);
        in_valid = 1; in_slot = SW'(slot); phase_inc = 20'(inc);
        phase_rst = prst; mod_in = 10'(md); env_lvl = 10'(env);
        idx  = (md + int'(ph[slot] >> 10)) & 1023;
        expv = ref_sample(idx, env);
        if (!prst) ph[slot] = ph[slot] + 20'(inc);
        @(negedge clk);
        chk(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
        chk(out_slot == SW'(slot), {req, " slot"}, int'(out_slot), slot);
        chk(int'(out_sample) == expv, {req, " sample"}, int'(out_sample), expv);
        last_smp = int'(out_sample);
        in_valid = 0;
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(out_sample == 0, "R1 sample after reset", int'(out_sample), 0);
        for (int s = 0; s < NS; s++) op(s, 0, 0, 0, 0, "R1 phase zero");
    endtask

    task automatic t_accum;
        for (int i = 0; i < 6; i++) op(1, 20'h1D400 + i * 20'h00377, 0, 0, 0, "R2 accumulate");
        op(1, 0, 0, 10'h3F0, 3, "R4 modulation wrap");
        op(1, 0, 0, 10'h155, 40, "R4 modulation offset");
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 5; i++) op(2, 20'hFFC00 - i * 20'h5000, 0, 0, 0, "R2 wrap 2^20");
        op(2, 0, 0, 0, 0, "R2 after wrap");
    endtask

    task automatic t_hold;
        op(3, 20'h2A800, 0, 0, 0, "R3 preload");
        op(3, 20'h7F000, 1, 0, 0, "R3 suppressed step");
        op(3, 20'h7F000, 1, 0, 0, "R3 phase unchanged");
        op(3, 20'h0, 0, 0, 0, "R3 phase unchanged final");
    endtask

    task automatic t_fold;
        int a;
        op(0, 0, 0, 10'h0FF, 0, "R5 fold below");
        a = last_smp;
        op(0, 0, 0, 10'h100, 0, "R5 fold above");
        chk(a == last_smp, "R5 mirror symmetric", last_smp, a);
        op(0, 0, 0, 10'h040, 0, "R5 rising");
        op(0, 0, 0, 10'h1BF, 0, "R5 falling mirror");
        chk(a == 8168, "R7 peak magnitude", a, 8168);
    endtask

    task automatic t_env;
        op(0, 0, 0, 10'h100, 10'h3FF, "R6 full attenuation");
        chk(last_smp == 0, "R6 silent at max env", last_smp, 0);
        op(0, 0, 0, 10'h100, 64, "R6 one octave");
        chk(last_smp == 4084, "R7 one octave halves", last_smp, 4084);
        op(0, 0, 0, 10'h020, 200, "R6 mid env");
        op(0, 0, 0, 10'h000, 0, "R7 smallest index");
    endtask

    task automatic t_sign;
        op(0, 0, 0, 10'h300, 0, "R8 negative peak");
        chk(last_smp == -8168, "R8 negative peak value", last_smp, -8168);
        op(0, 0, 0, 10'h27F, 10, "R8 negative half");
        op(0, 0, 0, 10'h1FF, 10, "R8 positive end");
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 0; env_lvl = 0; mod_in = 10'h100;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle valid", int'(out_valid), 0);
        chk(out_sample == 0, "R9 idle sample", int'(out_sample), 0);
    endtask

    task automatic t_slots;
        for (int r = 0; r < 3; r++)
            for (int s = 1; s < NS; s++)
                op(s, 20'h0C400 * s + r * 20'h1000, 0, s * 7, r, "R10 interleave");
        op(0, 0, 0, 0, 0, "R10 slot0 untouched");
    endtask

    initial begin
        for (int s = 0; s < NS; s++) ph[s] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_accum();
        t_wrap();
        t_hold();
        t_fold();
        t_env();
        t_sign();
        t_idle();
        t_slots();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule